// File: doc/BRIEF.md
# Memory Port Arbiter

This block decides which master drives a single on-chip memory port when more than one wants it. There are two competing sides. The processor side brings two requests, a data (operand) access and an instruction fetch. The other side is a shared bus used by the DMA-style masters. The processor's two requests are first merged with a fixed order: a data access always goes ahead of a fetch. The merged request then competes with the DMA-side request under a mode chosen by a 2-bit priority field.

With a fixed code the DMA side always wins a contest. With the toggling code, a side that has just been granted drops to the lower rank for the next contest. The toggle state favours the DMA side after reset.

A grant is registered, one-hot, and held until the granted master raises `done`. Arbitration happens only while the port is idle. A one-cycle `grant_vld` strobe marks each new grant. When the port is built read-only, a processor data write that wins arbitration is refused. It receives a one-cycle `err` pulse and no grant, and the port then rests for that cycle.

Top module: `mem_port_arbiter`

## Requirements
- R1: After reset, `grant` is 3'b000 and `grant_vld` and `err` are low.
- R2: `grant` has at most one bit set. Bit 0 is the operand access, bit 1 is the instruction fetch, and bit 2 is the DMA side.
- R3: A request present in an idle cycle produces its grant at the next clock edge. `grant_vld` is high for exactly that first grant cycle.
- R4: A grant stays unchanged, and all requests are ignored, until `done` is sampled high. The grant then clears at the next edge. The port is idle in the cycle after it clears.
- R5: When the processor side wins, an operand request takes precedence over an instruction-fetch request.
- R6: When `prio_mode` is 2'b00, 2'b10 or 2'b11 (fixed), a DMA-side request wins over any processor-side request.
- R7: When `prio_mode` is 2'b01 (toggled) and both sides request, the side not granted most recently wins. The DMA side is favoured after reset.
- R8: The toggle state changes only on grants issued in toggled mode. Grants in fixed mode and refused writes leave it unchanged.
- R9: With READ_ONLY=1, a winning operand request with `op_we`=1 gets no grant. Instead `err` is high for one cycle at the next edge, and the cycle after that pulse does no arbitration.
- R10: `done` has no effect while no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prio_mode | input | 2 | Arbitration mode: 2'b01 toggled, other codes fixed |
| op_req | input | 1 | Processor operand access request |
| op_we | input | 1 | Operand access is a write |
| if_req | input | 1 | Processor instruction-fetch request (read) |
| dma_req | input | 1 | DMA-side bus request |
| done | input | 1 | Granted master finished its transfer |
| grant | output | 3 | One-hot grant {dma, fetch, operand} |
| grant_vld | output | 1 | One-cycle strobe on a new grant |
| err | output | 1 | One-cycle pulse for a refused operand write |

## Verification
A grant, its strobe and an error pulse all appear one edge after the idle cycle in which the request was presented. A grant clears one edge after `done` is sampled. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each result is read exactly one edge after its cause. A reference model in the bench tracks the toggle state across the sweep of every mode code and request pattern. It is used to predict each grant.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
    localparam int GNT_W = 3;
    localparam int G_OP  = 0;
    localparam int G_IF  = 1;
    localparam int G_DMA = 2;
    localparam int CPU_W = 2;
    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_FIXED  = 2'b00;
    localparam logic [MODE_W-1:0] MODE_TOGGLE = 2'b01;

    typedef struct packed {
        logic [GNT_W-1:0] grant;
        logic             vld;
        logic             err;
        logic             pri_dma;
    } arb_state_t;
endpackage

// File: rtl/mpa_cpu_merge.sv
module mpa_cpu_merge
    import mpa_pkg::*;
(
    input  logic             op_req,
    input  logic             op_we,
    input  logic             if_req,
    output logic             cpu_req,
    output logic [CPU_W-1:0] cpu_sel,
    output logic             cpu_wr
);
    always_comb begin
        cpu_req = op_req | if_req;
        cpu_sel = '0;
        if (op_req) begin
            cpu_sel[G_OP] = 1'b1;
        end else if (if_req) begin
            cpu_sel[G_IF] = 1'b1;
        end
        cpu_wr = op_req & op_we;
    end
endmodule

// File: rtl/mpa_side_pick.sv
module mpa_side_pick
    import mpa_pkg::*;
(
    input  logic [MODE_W-1:0] prio_mode,
    input  logic              pri_dma,
    input  logic              cpu_req,
    input  logic              dma_req,
    output logic              dma_win,
    output logic              cpu_win,
    output logic              toggle_en
);
    always_comb begin
        toggle_en = (prio_mode == MODE_TOGGLE);
        dma_win   = dma_req & (~cpu_req | ~toggle_en | pri_dma);
        cpu_win   = cpu_req & ~dma_win;
    end
endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter
    import mpa_pkg::*;
#(
    parameter bit READ_ONLY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] prio_mode,
    input  logic              op_req,
    input  logic              op_we,
    input  logic              if_req,
    input  logic              dma_req,
    input  logic              done,
    output logic [GNT_W-1:0]  grant,
    output logic              grant_vld,
    output logic              err
);
    arb_state_t st_d, st_q;

    logic             cpu_req;
    logic [CPU_W-1:0] cpu_sel;
    logic             cpu_wr;
    logic             dma_win;
    logic             cpu_win;
    logic             toggle_en;
    logic             wr_block;
    logic             busy;
    logic             idle;

    mpa_cpu_merge u_merge (
        .op_req  (op_req),
        .op_we   (op_we),
        .if_req  (if_req),
        .cpu_req (cpu_req),
        .cpu_sel (cpu_sel),
        .cpu_wr  (cpu_wr)
    );

    mpa_side_pick u_pick (
        .prio_mode (prio_mode),
        .pri_dma   (st_q.pri_dma),
        .cpu_req   (cpu_req),
        .dma_req   (dma_req),
        .dma_win   (dma_win),
        .cpu_win   (cpu_win),
        .toggle_en (toggle_en)
    );

    generate
        if (READ_ONLY) begin : g_ro
            assign wr_block = cpu_wr;
        end else begin : g_rw
            assign wr_block = 1'b0;
        end
    endgenerate

    assign busy = |st_q.grant;
    assign idle = ~busy & ~st_q.err;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;
        if (busy) begin
            if (done) begin
                st_d.grant = '0;
            end
        end else if (idle) begin
            if (dma_win) begin
                st_d.grant        = '0;
                st_d.grant[G_DMA] = 1'b1;
                st_d.vld          = 1'b1;
                if (toggle_en) begin
                    st_d.pri_dma = 1'b0;
                end
            end else if (cpu_win) begin
                if (wr_block) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.grant = {1'b0, cpu_sel};
                    st_d.vld   = 1'b1;
                    if (toggle_en) begin
                        st_d.pri_dma = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.grant   <= '0;
            st_q.vld     <= 1'b0;
            st_q.err     <= 1'b0;
            st_q.pri_dma <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant     = st_q.grant;
    assign grant_vld = st_q.vld;
    assign err       = st_q.err;
endmodule

// File: rtl/mpa_checker.sv
module mpa_checker
    import mpa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] prio_mode,
    input logic              op_req,
    input logic              op_we,
    input logic              if_req,
    input logic              dma_req,
    input logic              done,
    input logic [GNT_W-1:0]  grant,
    input logic              grant_vld,
    input logic              err
);
    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |=> !grant_vld);

    // R3
    vld_has_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (grant != '0));

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && !done) |=> (grant == $past(grant)));

    // R4
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && done) |=> (grant == '0));

    // R5
    op_over_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant == '0) && !err && op_req && !op_we && !dma_req) |=> (grant == 3'b001));

    // R6
    fixed_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant == '0) && !err && dma_req && (prio_mode != MODE_TOGGLE)) |=> (grant == 3'b100));

    // R9
    err_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (grant == '0) && !grant_vld);

    // R9
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err && (grant == '0));
endmodule

bind mem_port_arbiter mpa_checker u_mpa_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .prio_mode (prio_mode),
    .op_req    (op_req),
    .op_we     (op_we),
    .if_req    (if_req),
    .dma_req   (dma_req),
    .done      (done),
    .grant     (grant),
    .grant_vld (grant_vld),
    .err       (err)
);

// File: tb/mem_port_arbiter_tb.sv
`timescale 1ns/1ps
module mem_port_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] prio_mode = 2'b00;
    logic       op_req = 1'b0;
    logic       op_we = 1'b0;
    logic       if_req = 1'b0;
    logic       dma_req = 1'b0;
    logic       done = 1'b0;
    logic [2:0] grant;
    logic       grant_vld;
    logic       err;

    int n_chk = 0;
    int n_fail = 0;
    bit m_pri_dma;

    always #2.5 clk = ~clk;

    mem_port_arbiter #(.READ_ONLY(1'b1)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .prio_mode (prio_mode),
        .op_req    (op_req),
        .op_we     (op_we),
        .if_req    (if_req),
        .dma_req   (dma_req),
        .done      (done),
        .grant     (grant),
        .grant_vld (grant_vld),
        .err       (err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_in();
        op_req = 1'b0; op_we = 1'b0; if_req = 1'b0; dma_req = 1'b0; done = 1'b0;
    endtask

    task automatic trial(input logic [1:0] mode, input logic [3:0] pat);
        logic [2:0] e_gnt;
        bit e_err;
        bit tog;
        bit cpu_any;
        bit dma_w;
        e_gnt = 3'b000;
        e_err = 1'b0;
        tog = (mode == 2'b01);
        @(negedge clk);
        prio_mode = mode;
        op_req = pat[0]; op_we = pat[1]; if_req = pat[2]; dma_req = pat[3]; done = 1'b0;
        cpu_any = pat[0] | pat[2];
        dma_w = pat[3] && (!cpu_any || !tog || m_pri_dma);
        if (dma_w) begin
            e_gnt = 3'b100;
            if (tog) m_pri_dma = 1'b0;
        end else if (cpu_any) begin
            if (pat[0] && pat[1]) e_err = 1'b1;
            else begin
                e_gnt = pat[0] ? 3'b001 : 3'b010;
                if (tog) m_pri_dma = 1'b1;
            end
        end
        @(negedge clk);
        // R5 R6 R7 R8: winner per model
        check(grant == e_gnt, "R5/R6/R7/R8 grant", grant, e_gnt);
        // R3: strobe on first grant cycle
        check(grant_vld == (e_gnt != 0), "R3 grant_vld", grant_vld, e_gnt != 0);
        // R9: refused write
        check(err == e_err, "R9 err", err, e_err);
        if (e_gnt != 0) begin
            // R4: flip requests while busy, must be ignored
            op_req = ~pat[0]; op_we = 1'b0; if_req = ~pat[2]; dma_req = ~pat[3];
            @(negedge clk);
            check(grant == e_gnt, "R4 hold", grant, e_gnt);
            check(grant_vld == 1'b0, "R3 strobe once", grant_vld, 0);
            clear_in();
            done = 1'b1;
            @(negedge clk);
            check(grant == 3'b000, "R4 release", grant, 0);
            done = 1'b0;
        end else if (e_err) begin
            clear_in();
            @(negedge clk);
            check(err == 1'b0, "R9 single pulse", err, 0);
            check(grant == 3'b000, "R9 no grant", grant, 0);
        end else begin
            clear_in();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(grant == 3'b000, "R1 grant", grant, 0);
        check(grant_vld == 1'b0, "R1 grant_vld", grant_vld, 0);
        check(err == 1'b0, "R1 err", err, 0);
        rst_n = 1'b1;
        m_pri_dma = 1'b1;
        // R7: right after reset, toggled mode favours DMA side
        trial(2'b01, 4'b1101);
        trial(2'b01, 4'b1101);
        trial(2'b01, 4'b1001);
        // R10: done while idle has no effect
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        check(grant == 3'b000, "R10 done idle", grant, 0);
        check(grant_vld == 1'b0, "R10 done idle vld", grant_vld, 0);
        done = 1'b0;
        trial(2'b00, 4'b0100);
        for (int rep = 0; rep < 2; rep++) begin
            for (int m = 0; m < 4; m++) begin
                for (int p = 0; p < 16; p++) begin
                    trial(2'(m), 4'(p));
                end
            end
        end
        // R8: toggled contests after fixed-mode grants and refused writes
        for (int p = 0; p < 16; p++) begin
            trial(2'b01, 4'b1101);
            trial(2'b01, 4'(p));
        end
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule